// File: doc/BRIEF.md
# Serial/Parallel Delay Code Register

This block holds the code that sets a programmable delay. It contains one or more 8-bit code units. The code can be loaded in two ways. In parallel mode each unit takes its slice of a wide parallel bus. While the enable is high the slice passes straight through, and when the enable goes low the last value taken is held. In serial mode the units form one long shift register. A host shifts bits in through a serial input and reads bits back through a serial output, most significant bit first, using a serial clock.

Enable and the serial clock are treated as level inputs that are synchronous to the system clock `clk`. Their edges are found by comparing each level with its value at the previous clock edge. During a serial access the active code stays frozen. When the enable falls, the shifted contents become the new code. A serial read is destructive: the bits that come out are replaced by the bits that go in. A host that wants to keep the setting must shift the same bits back in before it lowers the enable.

Top module: `dly_code_reg`

## Requirements
- R1: While `rst` is high at a clock edge, all code bits and the shift contents become 0, and `sout` is 0 after that edge.
- R2: With `mode_sel` = 1 (parallel) and `enable` high at a clock edge, `code` takes the value of `pbus` at that edge.
- R3: With `mode_sel` = 1 and `enable` low at a clock edge, `code` keeps the value taken at the last edge where `enable` was high. `pbus` is ignored.
- R4: With `mode_sel` = 0 (serial) and `enable` high, `sout` shows bit 7 of the last unit's shift stage in the same cycle, with no `sclk` edge needed. Outside a serial access the shift stage equals the code.
- R5: A serial clock rise (`sclk` high at a clock edge and low at the previous edge) during a serial access moves `sin` into bit 0 of unit 0, and moves each unit's bit 7 into bit 0 of the next unit. `sout` then shows the next lower bit. A rise in the same cycle as the enable rise counts.
- R6: During a serial access, `code` does not change.
- R7: A falling `enable` (low at an edge, high at the previous edge) with `mode_sel` = 0 copies the shift contents into `code`. Reading is therefore destructive.
- R8: With N units, 8×N serial bits are sent as 8-bit groups, each group MSB first. The first group ends in the last unit (`code` bits [8N-1:8N-8]) and the last group ends in unit 0.
- R9: While `enable` is low, `sclk` is ignored and `sout` keeps its last value.
- R10: A serial clock rise at the same edge as the enable fall is ignored. The commit uses the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 1 = parallel loading, 0 = serial programming |
| enable | input | 1 | Access enable / parallel latch control |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| sin | input | 1 | Serial data into unit 0 |
| pbus | input | 8×NUM_UNITS | Parallel code, unit i on bits [8i+7:8i] |
| code | output | 8×NUM_UNITS | Active delay code of all units |
| sout | output | 1 | Serial data out of the last unit |

## Verification
Two events can land on the same clock edge: a serial clock rise and a change of the enable. The bench drives them together. It raises `sclk` in the cycle where `enable` drops, and it raises both `sclk` and `enable` in one cycle. The model, written independently, expects the shift to be dropped in the first case and taken in the second. The committed code after the collision is also compared with a value worked out by hand.

// File: rtl/dly_pkg.sv
package dly_pkg;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } dly_mode_e;

  // Per-cycle control events shared by every code unit
  typedef struct packed {
    logic access;     // serial window open
    logic shift_evt;  // serial clock rise inside the window
    logic commit;     // enable fell while in serial mode
    logic par_load;   // parallel bus taken this edge
  } dly_ctrl_t;

  function automatic logic serial_window(dly_mode_e mode, logic en);
    return (mode == MODE_SERIAL) && en;
  endfunction

endpackage

// File: rtl/dly_edge_det.sv
module dly_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = ~level & prev_q;
    end else begin : g_rise
      assign edge_o = level & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_sel,
  input  logic      enable,
  input  logic      sclk,
  output dly_ctrl_t ctrl
);
  dly_mode_e mode;
  logic      sck_rise;
  logic      en_fall;

  assign mode = dly_mode_e'(mode_sel);

  dly_edge_det #(.FALLING(1'b0)) u_sck (
    .clk(clk), .rst(rst), .level(sclk), .edge_o(sck_rise));

  dly_edge_det #(.FALLING(1'b1)) u_en (
    .clk(clk), .rst(rst), .level(enable), .edge_o(en_fall));

  always_comb begin
    ctrl.access    = serial_window(mode, enable);
    ctrl.shift_evt = ctrl.access & sck_rise;
    ctrl.commit    = en_fall & (mode == MODE_SERIAL);
    ctrl.par_load  = (mode == MODE_PARALLEL) & enable;
  end

  // R10: a shift, a commit and a parallel load never coincide
  p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.shift_evt, ctrl.commit, ctrl.par_load}));
endmodule

// File: rtl/dly_unit_cell.sv
module dly_unit_cell
  import dly_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dly_ctrl_t         ctrl,
  input  logic [CODE_W-1:0] par_in,
  input  logic              ser_in,
  output logic [CODE_W-1:0] code_o,
  output logic              ser_o
);
  localparam int MSB = CODE_W - 1;

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] shift_q, shift_d;
  logic              hold_q;

  function automatic logic [CODE_W-1:0] shift_msb_first(
    logic [CODE_W-1:0] cur, logic b);
    return {cur[CODE_W-2:0], b};
  endfunction

  always_comb begin
    code_d = code_q;
    if (ctrl.par_load)    code_d = par_in;
    else if (ctrl.commit) code_d = shift_q;
  end

  always_comb begin
    if (ctrl.shift_evt)   shift_d = shift_msb_first(shift_q, ser_in);
    else if (ctrl.access) shift_d = shift_q;
    else                  shift_d = code_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      shift_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      code_q  <= code_d;
      shift_q <= shift_d;
      if (ctrl.access) hold_q <= shift_d[MSB];
    end
  end

  assign code_o = code_q;
  assign ser_o  = ctrl.access ? shift_q[MSB] : hold_q;

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.par_load |=> (code_q == $past(par_in)));

  p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.par_load && !ctrl.commit) |=> $stable(code_q));

  p_shift_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.shift_evt |=> (shift_q == {$past(shift_q[CODE_W-2:0]), $past(ser_in)}));

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.access |=> $stable(code_q));

  p_commit_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.commit |=> (code_q == $past(shift_q)));

  p_sout_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.access && !$past(ctrl.access)) |-> $stable(ser_o));
endmodule

// File: rtl/dly_code_reg.sv
module dly_code_reg
  import dly_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int NUM_UNITS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_sel,
  input  logic                        enable,
  input  logic                        sclk,
  input  logic                        sin,
  input  logic [CODE_W*NUM_UNITS-1:0] pbus,
  output logic [CODE_W*NUM_UNITS-1:0] code,
  output logic                        sout
);
  localparam int BUS_W = CODE_W * NUM_UNITS;

  dly_ctrl_t            ctrl;
  logic [NUM_UNITS:0]   link;   // serial chain, link[0] is the host input
  logic [BUS_W-1:0]     code_w;

  dly_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .enable(enable),
    .sclk(sclk), .ctrl(ctrl));

  assign link[0] = sin;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      dly_unit_cell #(.CODE_W(CODE_W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .par_in(pbus[u*CODE_W +: CODE_W]),
        .ser_in(link[u]),
        .code_o(code_w[u*CODE_W +: CODE_W]),
        .ser_o (link[u+1]));
    end
  endgenerate

  assign code = code_w;
  assign sout = link[NUM_UNITS];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (code == '0 && (!enable || mode_sel || !sout)));
endmodule

// File: tb/sim_dly_code_reg.sv
module sim_dly_code_reg;
  localparam int W   = 8;
  localparam int N   = 2;
  localparam int TOT = W * N;

  logic clk = 1'b0;
  logic rst = 1'b1, mode_sel = 1'b1, enable = 1'b0, sclk = 1'b0, sin = 1'b0;
  logic [TOT-1:0] pbus = '0;
  logic [TOT-1:0] code;
  logic sout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [TOT-1:0] code_m = '0, sh_m = '0;
  logic hold_m = 1'b0, ep_m = 1'b0, sp_m = 1'b0;

  always #10 clk = ~clk;

  dly_code_reg #(.CODE_W(W), .NUM_UNITS(N)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .enable(enable),
    .sclk(sclk), .sin(sin), .pbus(pbus), .code(code), .sout(sout));

  task automatic chk(input logic [TOT-1:0] act, input logic [TOT-1:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic model_sout();
    return (!mode_sel && enable) ? sh_m[TOT-1] : hold_m;
  endfunction

  task automatic model_edge();
    logic acc, rise, fall;
    logic [TOT-1:0] nc;
    if (rst) begin
      code_m = '0; sh_m = '0; hold_m = 0; ep_m = 0; sp_m = 0;
    end else begin
      acc  = !mode_sel && enable;
      rise = sclk && !sp_m;
      fall = !enable && ep_m && !mode_sel;
      nc = code_m;
      if (mode_sel && enable) nc = pbus;
      else if (fall)          nc = sh_m;
      if (acc && rise)        sh_m = {sh_m[TOT-2:0], sin};
      else if (!acc)          sh_m = nc;
      if (acc) hold_m = sh_m[TOT-1];
      code_m = nc;
      ep_m = enable;
      sp_m = sclk;
    end
  endtask

  task automatic step(input logic r, input logic m, input logic e, input logic sc,
                      input logic si, input logic [TOT-1:0] pb, input string tag);
    @(negedge clk);
    rst = r; mode_sel = m; enable = e; sclk = sc; sin = si; pbus = pb;
    #1;
    if (!r) chk({{(TOT-1){1'b0}}, sout}, {{(TOT-1){1'b0}}, model_sout()}, tag, "sout before edge");
    @(posedge clk);
    model_edge();
    #2;
    chk(code, code_m, tag, "code");
    chk({{(TOT-1){1'b0}}, sout}, {{(TOT-1){1'b0}}, model_sout()}, tag, "sout after edge");
  endtask

  // one serial bit: sclk high for a cycle, then low for a cycle
  task automatic ser_bit(input logic b, input string tag);
    step(0, 0, 1, 1, b, pbus, tag);
    step(0, 0, 1, 0, b, pbus, tag);
  endtask

  initial begin
    logic [TOT-1:0] wdata;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, '0, "R1");
    chk(code, '0, "R1", "code after reset");

    step(0, 1, 1, 0, 0, 16'h9A5C, "R2");
    step(0, 1, 1, 0, 0, 16'h1234, "R2");
    step(0, 1, 1, 0, 0, 16'hF00F, "R2");
    chk(code, 16'hF00F, "R2", "transparent load");

    step(0, 1, 0, 0, 0, 16'h0F0F, "R3");
    step(0, 1, 0, 0, 0, 16'hAAAA, "R3");
    chk(code, 16'hF00F, "R3", "latched value");

    // serial access: MSB of current code appears at once
    step(0, 0, 1, 0, 0, 16'hAAAA, "R4");
    chk({15'd0, sout}, 16'd1, "R4", "bit 15 without sclk edge");

    wdata = 16'hC3E1;
    for (int i = TOT - 1; i >= 0; i--) begin
      ser_bit(wdata[i], "R5");
      if (i == 8) chk(code, 16'hF00F, "R6", "code frozen mid access");
    end
    step(0, 0, 0, 0, 0, 16'hAAAA, "R7");
    chk(code, 16'hC3E1, "R8", "cascade order after commit");

    for (int i = 0; i < 4; i++) step(0, 0, 0, i[0], 1, 16'h5555, "R9");
    chk(code, 16'hC3E1, "R9", "sclk ignored while enable low");

    // sclk rise together with enable fall is dropped
    step(0, 0, 1, 0, 0, 16'h5555, "R10");
    ser_bit(1, "R10");
    ser_bit(0, "R10");
    ser_bit(1, "R10");
    step(0, 0, 0, 1, 1, 16'h5555, "R10");
    chk(code, 16'h1F0D, "R10", "commit ignores coincident sclk rise");
    step(0, 0, 0, 0, 0, 16'h5555, "R10");

    // enable rise and sclk rise in one cycle: the rise counts
    step(0, 0, 1, 1, 1, 16'h5555, "R5");
    step(0, 0, 1, 0, 0, 16'h5555, "R5");
    step(0, 0, 0, 0, 0, 16'h5555, "R7");
    chk(code, 16'h3E1B, "R5", "shift on opening edge");

    step(0, 1, 1, 0, 0, 16'h7E81, "R2");
    step(1, 1, 1, 0, 0, 16'h7E81, "R1");
    chk(code, '0, "R1", "reset mid run");
    step(0, 1, 0, 0, 0, 16'h7E81, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule